// File: doc/BRIEF.md
# Clock Source Enable and Stop-Mode Gating Controller

This block holds the per-source control state for four clock sources of a system clock generator: a slow internal RC, a fast internal RC, an external oscillator and a PLL. For each source the surrounding logic supplies an enable bit, a stop-enable bit and a low-power enable bit. It also supplies the current power state on a 3-bit code. The block works out whether each source should be running. It drives that decision to the oscillator as a run request and waits for the oscillator's ready answer.

A startup counter runs while a source is requested and ready. After a parameterised number of reference cycles it raises the source's valid flag. A source counts as available to the clock tree only when it is requested and valid. When a stop mode takes a source away, its valid flag falls. When the source comes back, the count starts again from zero.

Each source also has a range setting. A write to that setting is ignored while the source is enabled.

Top module: `clksrc_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every valid flag, every range setting (to 0) and every startup count.
- R2: In run mode (stop_mode code 0), a source's run request equals its enable bit; a source whose enable bit is 0 is never requested in any mode.
- R3: A source's valid flag rises at the clock edge that completes STARTUP_CYC consecutive sampled cycles with its run request and oscillator ready both high. Its clock-available output is high exactly when its run request and valid flag are both high.
- R4: When a source's run request or ready is low at a clock edge, its valid flag is low after that edge and its startup count restarts from zero.
- R5: A range write (range_wr bit s, value range_wdata) to source s takes effect at the next edge only when src_en bit s is 0; while it is 1 the write is ignored. Source s occupies range_q bits [s*RANGE_W +: RANGE_W].
- R6: The slow RC (source 0) stays requested in normal stop (code 1) when enable and stop-enable are 1, and in very-low-power stop (code 2) only if its low-power enable is also 1.
- R7: The fast RC (source 1) and the PLL (source 3) stay requested only in normal stop (code 1), with enable and stop-enable both 1.
- R8: The external oscillator (source 2) stays requested in normal stop (code 1) with enable and stop-enable. In very-low-power stop (code 2) and low-leakage stop (code 3) it also needs its low-power enable.
- R9: In very-low-leakage stop (code 4), and for the unused codes 5 to 7, no source is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_mode | input | 3 | Power state: 0 run, 1 normal stop, 2 very-low-power stop, 3 low-leakage stop, 4 very-low-leakage stop |
| src_en | input | 4 | Per-source enable (bit 0 slow RC, 1 fast RC, 2 external oscillator, 3 PLL) |
| src_sten | input | 4 | Per-source stop-enable |
| src_lpen | input | 4 | Per-source low-power enable |
| osc_rdy | input | 4 | Per-source ready answer from the oscillator |
| range_wr | input | 4 | Per-source range write strobe |
| range_wdata | input | RANGE_W | Range value to write |
| run_req | output | 4 | Per-source run request to the oscillator |
| src_valid | output | 4 | Per-source valid flag |
| clk_avail | output | 4 | Per-source clock available to the clock tree |
| range_q | output | 4*RANGE_W | Per-source range settings |

## Verification
Some rules are checked by the assertions on every cycle:
- the stop-mode rules that forbid a run request;
- the valid flag falling after a cycle without request or ready;
- the valid flag rising only after a requested, ready cycle;
- a range setting holding still while its source is enabled.

Other behaviour needs the bench's scenarios. The full request truth table is swept over all eight mode codes and all 4096 control-bit combinations. The exact edge on which valid rises is checked, as is the restart of the count after a stop-mode loss. The bench also checks that a write refused under enable leaves the stored value visible and unchanged.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

    localparam int NUM_SRC = 4;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_FAST = 2'd1,
        SRC_XOSC = 2'd2,
        SRC_PLL  = 2'd3
    } src_id_e;

    typedef enum logic [2:0] {
        PM_RUN     = 3'd0,
        PM_STOP    = 3'd1,
        PM_VLPSTOP = 3'd2,
        PM_LLSTOP  = 3'd3,
        PM_VLLSTOP = 3'd4
    } pmode_e;

    typedef struct packed {
        logic en;
        logic sten;
        logic lpen;
    } src_ctl_t;

    // Decide whether a source keeps running in the given power state.
    function automatic logic src_keep(src_id_e id, logic [2:0] mode, src_ctl_t c);
        logic kept;
        kept = 1'b0;
        case (mode)
            3'd0:    kept = 1'b1;
            3'd1:    kept = c.sten;
            3'd2:    kept = c.sten & c.lpen & ((id == SRC_SLOW) | (id == SRC_XOSC));
            3'd3:    kept = c.sten & c.lpen & (id == SRC_XOSC);
            default: kept = 1'b0;
        endcase
        return c.en & kept;
    endfunction

endpackage

// File: rtl/csrc_startup.sv
module csrc_startup #(
    parameter int STARTUP_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic rdy,
    output logic valid
);
    localparam int CW = $clog2(STARTUP_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STARTUP_CYC);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;
    logic          run;

    assign run    = req & rdy;
    assign cnt_nx = (cnt == LIMIT) ? cnt : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            valid <= 1'b0;
        end else if (!run) begin
            cnt   <= '0;
            valid <= 1'b0;
        end else begin
            cnt   <= cnt_nx;
            valid <= (cnt_nx == LIMIT);
        end
    end

    // R4: a cycle without request or ready clears the flag
    a_r4_valid_clears: assert property (@(posedge clk) disable iff (rst)
        !(req && rdy) |=> !valid);

    // R3: the flag only rises after a requested, ready cycle
    a_r3_valid_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(req && rdy));

endmodule

// File: rtl/csrc_range.sv
module csrc_range #(
    parameter int RANGE_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               wr,
    input  logic [RANGE_W-1:0] wdata,
    output logic [RANGE_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr && !en) begin
            q <= wdata;
        end
    end

    // R5: the setting is frozen while the source is enabled
    a_r5_range_frozen: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(q));

endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
    import clksrc_pkg::*;
#(
    parameter int STARTUP_CYC = 64,
    parameter int RANGE_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [2:0]                 stop_mode,
    input  logic [NUM_SRC-1:0]         src_en,
    input  logic [NUM_SRC-1:0]         src_sten,
    input  logic [NUM_SRC-1:0]         src_lpen,
    input  logic [NUM_SRC-1:0]         osc_rdy,
    input  logic [NUM_SRC-1:0]         range_wr,
    input  logic [RANGE_W-1:0]         range_wdata,
    output logic [NUM_SRC-1:0]         run_req,
    output logic [NUM_SRC-1:0]         src_valid,
    output logic [NUM_SRC-1:0]         clk_avail,
    output logic [NUM_SRC*RANGE_W-1:0] range_q
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        src_ctl_t ctl;
        assign ctl.en   = src_en[g];
        assign ctl.sten = src_sten[g];
        assign ctl.lpen = src_lpen[g];

        assign run_req[g]   = src_keep(src_id_e'(2'(g)), stop_mode, ctl);
        assign clk_avail[g] = run_req[g] & src_valid[g];

        csrc_startup #(.STARTUP_CYC(STARTUP_CYC)) u_startup (
            .clk   (clk),
            .rst   (rst),
            .req   (run_req[g]),
            .rdy   (osc_rdy[g]),
            .valid (src_valid[g])
        );

        csrc_range #(.RANGE_W(RANGE_W)) u_range (
            .clk   (clk),
            .rst   (rst),
            .en    (src_en[g]),
            .wr    (range_wr[g]),
            .wdata (range_wdata),
            .q     (range_q[g*RANGE_W +: RANGE_W])
        );
    end

    // R9: nothing runs in the deepest stop or unused codes
    a_r9_deep_off: assert property (@(posedge clk) disable iff (rst)
        (stop_mode >= 3'd4) |-> (run_req == '0));

    // R7: fast RC and PLL run only in run mode or normal stop
    a_r7_fast_pll_mode: assert property (@(posedge clk) disable iff (rst)
        (run_req[1] || run_req[3]) |-> (stop_mode <= 3'd1));

    // R6: slow RC never requested beyond very-low-power stop
    a_r6_slow_mode: assert property (@(posedge clk) disable iff (rst)
        run_req[0] |-> (stop_mode <= 3'd2));

    // R8: external oscillator in low-power stops needs its low-power bit
    a_r8_xosc_lp: assert property (@(posedge clk) disable iff (rst)
        (run_req[2] && (stop_mode == 3'd2 || stop_mode == 3'd3)) |-> src_lpen[2]);

    // R2: no request without enable
    a_r2_req_needs_en: assert property (@(posedge clk) disable iff (rst)
        (run_req & ~src_en) == '0);

endmodule

// File: tb/clksrc_ctrl_tb.sv
module clksrc_ctrl_tb;
    localparam int N  = 5;
    localparam int RW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    stop_mode;
    logic [3:0]    src_en, src_sten, src_lpen, osc_rdy, range_wr;
    logic [RW-1:0] range_wdata;
    logic [3:0]    run_req, src_valid, clk_avail;
    logic [4*RW-1:0] range_q;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    clksrc_ctrl #(.STARTUP_CYC(N), .RANGE_W(RW)) u_dut (
        .clk(clk), .rst(rst), .stop_mode(stop_mode),
        .src_en(src_en), .src_sten(src_sten), .src_lpen(src_lpen),
        .osc_rdy(osc_rdy), .range_wr(range_wr), .range_wdata(range_wdata),
        .run_req(run_req), .src_valid(src_valid), .clk_avail(clk_avail),
        .range_q(range_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Expected request of one source, from the stop-mode rules
    function automatic logic exp_req(int s, int m, logic en, logic st, logic lp);
        if (!en)    return 1'b0;
        if (m == 0) return 1'b1;
        if (m == 1) return st;
        if (m == 2) return st && lp && (s == 0 || s == 2);
        if (m == 3) return st && lp && (s == 2);
        return 1'b0;
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; stop_mode = 3'd0; src_en = '0; src_sten = '0; src_lpen = '0;
        osc_rdy = '0; range_wr = '0; range_wdata = '0;
        step(); step();
        // R1: reset state
        chk("R1 valid", 32'(src_valid), 0);
        chk("R1 range", 32'(range_q), 0);
        chk("R1 avail", 32'(clk_avail), 0);
        rst = 1'b0;
        step();

        // R2 R6 R7 R8 R9: exhaustive request sweep
        for (int m = 0; m < 8; m++) begin
            for (int v = 0; v < 4096; v++) begin
                logic [3:0] e;
                stop_mode = 3'(m);
                src_en = v[3:0]; src_sten = v[7:4]; src_lpen = v[11:8];
                #1;
                e = '0;
                for (int s = 0; s < 4; s++)
                    e[s] = exp_req(s, m, src_en[s], src_sten[s], src_lpen[s]);
                chk($sformatf("R2/R6/R7/R8/R9 mode %0d", m), 32'(run_req), 32'(e));
            end
        end
        step();
        stop_mode = 3'd0; src_en = '0; src_sten = '0; src_lpen = '0;
        step(); step();

        // R3: startup count on the slow RC
        src_en = 4'b0001; osc_rdy = 4'b1111;
        for (int i = 1; i < N; i++) begin
            step();
            chk("R3 valid low during count", 32'(src_valid[0]), 0);
        end
        step();
        chk("R3 valid at count end", 32'(src_valid[0]), 1);
        chk("R3 avail", 32'(clk_avail), 32'h1);

        // R4: ready drop clears valid, count restarts
        osc_rdy = 4'b0000;
        step();
        chk("R4 valid after ready drop", 32'(src_valid[0]), 0);
        osc_rdy = 4'b1111;
        for (int i = 1; i < N; i++) step();
        chk("R4 restart count not done", 32'(src_valid[0]), 0);
        step();
        chk("R4 restart count done", 32'(src_valid[0]), 1);

        // R6 R4: very-low-power stop without low-power bit removes slow RC
        src_sten = 4'b0001; stop_mode = 3'd2;
        #1;
        chk("R6 avail gone in stop", 32'(clk_avail[0]), 0);
        step();
        chk("R4 valid cleared in stop", 32'(src_valid[0]), 0);
        stop_mode = 3'd0;
        for (int i = 1; i < N; i++) step();
        chk("R4 wake count not done", 32'(src_valid[0]), 0);
        step();
        chk("R4 wake count done", 32'(src_valid[0]), 1);

        // R6: with low-power bit the slow RC survives
        src_lpen = 4'b0001; stop_mode = 3'd2;
        step();
        chk("R6 slow kept in vlp stop", 32'(clk_avail[0]), 1);
        stop_mode = 3'd0; src_en = '0; src_sten = '0; src_lpen = '0;
        step();

        // R5: range writes
        range_wr = 4'hF; range_wdata = 2'd3;
        step();
        chk("R5 write while disabled", 32'(range_q), 32'hFF);
        src_en = 4'b0010; range_wdata = 2'd1;
        step();
        chk("R5 write ignored while enabled", 32'(range_q), 32'h5D);
        src_en = 4'b0000; range_wr = 4'b0010; range_wdata = 2'd2;
        step();
        chk("R5 write after disable", 32'(range_q), 32'h59);
        range_wr = '0;
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule